// File: doc/BRIEF.md
# Almost-Flag Offset Register Unit

This unit stores the two thresholds used by the almost-empty and almost-full flags of a deep FIFO: an empty-side offset and a full-side offset. Each is as wide as the log2 of the FIFO depth. While master reset is held, the load select input does two things. It chooses which of two default thresholds goes into both registers, and it fixes whether later programming is bit-serial or word-parallel. Partial reset keeps the thresholds and the chosen method. It only restarts the load sequence.

In serial mode, each clock with the serial enable high stores one bit from the serial data input. Bits arrive least significant first, filling the empty offset and then the full offset, and the sequence then wraps back. In parallel mode, the load select gates offset access. With load high, write enable stores the bus word at the current word position, and read enable returns the stored word on the readback bus. A single word pointer walks the slots empty-low, empty-high, full-low, full-high and wraps. The flag comparison itself lives elsewhere.

Top module: `flag_offset_unit`

## Requirements
- R1: A clock with master reset high and load select low sets both offsets to 127 and selects parallel programming.
- R2: A clock with master reset high and load select high sets both offsets to 1023 and selects serial programming.
- R3: Master reset clears the readback word to 0 and returns the word pointer and the serial bit position to their first slot.
- R4: A clock with partial reset high (and master reset low) keeps both offsets and the programming method, clears the readback word and restarts both the word pointer and the serial bit position.
- R5: In serial mode, each clock with serial enable high stores the serial bit at the next position: positions 0 to 15 are empty-offset bits 0 to 15, positions 16 to 31 are full-offset bits 0 to 15, then the position wraps to 0. Bits not yet reached keep their value.
- R6: In serial mode, load/write and load/read have no effect on the offsets or the readback word.
- R7: In parallel mode, a clock with load and write enable high stores the 9-bit bus at the word pointer and advances it. Slot 0 takes offset bits 8:0 of the empty offset, slot 1 takes its bits 15:9 from bus bits 6:0 (bus bits 8:7 dropped), and slots 2 and 3 do the same for the full offset. After slot 3 the pointer wraps to slot 0.
- R8: In parallel mode, a clock with load and read enable high places the word at the pointer on the readback bus, zero-padded above the offset width, and advances the pointer.
- R9: With load low, write and read enables change neither offsets, pointer nor readback word.
- R10: In parallel mode, serial enable has no effect.
- R11: Load with write and read enable in the same clock returns the slot's contents from before the write, stores the new word, and advances the pointer by exactly one slot.
- R12: While master reset is high, the serial enable, serial bit and write/read enables have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| mrst_i | input | 1 | Master reset, synchronous, active high |
| prst_i | input | 1 | Partial reset, synchronous, active high |
| ld_i | input | 1 | Load select: default/method choice during master reset, offset access gate afterwards |
| ser_en_i | input | 1 | Serial load enable |
| ser_bit_i | input | 1 | Serial data bit (ignored during master reset) |
| wr_en_i | input | 1 | Word write enable |
| rd_en_i | input | 1 | Word readback enable |
| wr_data_i | input | 9 | Write data word |
| empty_ofs_o | output | 16 | Almost-empty offset |
| full_ofs_o | output | 16 | Almost-full offset |
| rd_data_o | output | 9 | Readback word |

## Verification
A parallel write and a readback can land in the same clock when load, write enable and read enable are all high. The bench provokes this after the pointer has wrapped to slot 0. It then expects the readback to show the old slot contents, the empty offset to carry the new word, and the next plain readback to come from slot 1. That last result proves the pointer moved exactly once. Master reset colliding with serial and write activity is also driven, and is judged by the defaults being intact.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic {
    PROG_PAR = 1'b0,
    PROG_SER = 1'b1
  } prog_mode_e;
endpackage

// File: rtl/ofs_mode_ctl.sv
module ofs_mode_ctl
  import ofs_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int DFLT_LO = 127,
  parameter int DFLT_HI = 1023
) (
  input  logic             clk_i,
  input  logic             mrst_i,
  input  logic             prst_i,
  input  logic             ld_i,
  output prog_mode_e       mode_o,
  output logic [OFS_W-1:0] dflt_o
);
  prog_mode_e mode_q;

  // default picked by load select, only consumed while master reset is high
  assign dflt_o = ld_i ? OFS_W'(DFLT_HI) : OFS_W'(DFLT_LO);

  always_ff @(posedge clk_i) begin
    if (mrst_i) mode_q <= ld_i ? PROG_SER : PROG_PAR;
  end

  assign mode_o = mode_q;

  a_r1_par_on_low: assert property (@(posedge clk_i) disable iff (prst_i)
    (mrst_i && !ld_i) |=> (mode_q == PROG_PAR));
  a_r2_ser_on_high: assert property (@(posedge clk_i) disable iff (prst_i)
    (mrst_i && ld_i) |=> (mode_q == PROG_SER));
  a_r4_mode_kept: assert property (@(posedge clk_i) disable iff (mrst_i)
    prst_i |=> $stable(mode_q));
endmodule

// File: rtl/ofs_ser_ctl.sv
module ofs_ser_ctl
  import ofs_pkg::*;
#(
  parameter int NBITS  = 32,
  parameter int SIDX_W = 5
) (
  input  logic              clk_i,
  input  logic              mrst_i,
  input  logic              prst_i,
  input  prog_mode_e        mode_i,
  input  logic              ser_en_i,
  output logic              ser_we_o,
  output logic [SIDX_W-1:0] ser_idx_o
);
  localparam logic [SIDX_W-1:0] LAST = SIDX_W'(NBITS - 1);

  logic [SIDX_W-1:0] idx_q;

  assign ser_we_o  = !mrst_i && !prst_i && (mode_i == PROG_SER) && ser_en_i;
  assign ser_idx_o = idx_q;

  always_ff @(posedge clk_i) begin
    if (mrst_i || prst_i)  idx_q <= '0;
    else if (ser_we_o)     idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  a_r5_bit_wrap: assert property (@(posedge clk_i) disable iff (mrst_i)
    (ser_we_o && idx_q == LAST) |=> (idx_q == '0));
  a_r4_bitpos_restart: assert property (@(posedge clk_i) disable iff (mrst_i)
    prst_i |=> (idx_q == '0));
endmodule

// File: rtl/ofs_par_ctl.sv
module ofs_par_ctl
  import ofs_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int PIDX_W = 2
) (
  input  logic              clk_i,
  input  logic              mrst_i,
  input  logic              prst_i,
  input  prog_mode_e        mode_i,
  input  logic              ld_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic              par_we_o,
  output logic              par_re_o,
  output logic [PIDX_W-1:0] par_idx_o
);
  localparam logic [PIDX_W-1:0] LAST = PIDX_W'(NWORDS - 1);

  logic              access;
  logic [PIDX_W-1:0] idx_q;

  assign access    = !mrst_i && !prst_i && (mode_i == PROG_PAR) && ld_i;
  assign par_we_o  = access && wr_en_i;
  assign par_re_o  = access && rd_en_i;
  assign par_idx_o = idx_q;

  // one step per clock even when write and readback coincide
  always_ff @(posedge clk_i) begin
    if (mrst_i || prst_i)         idx_q <= '0;
    else if (par_we_o || par_re_o) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  a_r7_word_wrap: assert property (@(posedge clk_i) disable iff (mrst_i)
    ((par_we_o || par_re_o) && idx_q == LAST) |=> (idx_q == '0));
  a_r9_ptr_hold: assert property (@(posedge clk_i) disable iff (mrst_i)
    (!ld_i && !prst_i) |=> $stable(idx_q));
endmodule

// File: rtl/flag_offset_unit.sv
module flag_offset_unit
  import ofs_pkg::*;
#(
  parameter int DEPTH   = 65536,
  parameter int BUS_W   = 9,
  parameter int DFLT_LO = 127,
  parameter int DFLT_HI = 1023
) (
  input  logic                       clk_i,
  input  logic                       mrst_i,
  input  logic                       prst_i,
  input  logic                       ld_i,
  input  logic                       ser_en_i,
  input  logic                       ser_bit_i,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [BUS_W-1:0]           wr_data_i,
  output logic [$clog2(DEPTH)-1:0]   empty_ofs_o,
  output logic [$clog2(DEPTH)-1:0]   full_ofs_o,
  output logic [BUS_W-1:0]           rd_data_o
);
  localparam int OFS_W  = $clog2(DEPTH);
  localparam int WPO    = (OFS_W + BUS_W - 1) / BUS_W;
  localparam int NWORDS = 2 * WPO;
  localparam int PADW   = WPO * BUS_W;
  localparam int ALLW   = 2 * OFS_W;
  localparam int SIDX_W = $clog2(ALLW);
  localparam int PIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  // word k of the packed store {full, empty}, zero-padded above OFS_W
  function automatic logic [BUS_W-1:0] word_get(logic [ALLW-1:0] all, int k);
    logic [OFS_W-1:0] rv;
    logic [PADW-1:0]  pad;
    rv  = OFS_W'(all >> ((k / WPO) * OFS_W));
    pad = PADW'(rv);
    return BUS_W'(pad >> ((k % WPO) * BUS_W));
  endfunction

  // overwrite word k; bus bits past OFS_W fall off
  function automatic logic [ALLW-1:0] word_put(logic [ALLW-1:0] all, int k,
                                                logic [BUS_W-1:0] d);
    logic [OFS_W-1:0] rv;
    logic [PADW-1:0]  pad;
    logic [PADW-1:0]  wm;
    logic [ALLW-1:0]  am;
    rv  = OFS_W'(all >> ((k / WPO) * OFS_W));
    pad = PADW'(rv);
    wm  = PADW'({BUS_W{1'b1}}) << ((k % WPO) * BUS_W);
    pad = (pad & ~wm) | (PADW'(d) << ((k % WPO) * BUS_W));
    am  = ALLW'({OFS_W{1'b1}}) << ((k / WPO) * OFS_W);
    return (all & ~am) | (ALLW'(OFS_W'(pad)) << ((k / WPO) * OFS_W));
  endfunction

  function automatic logic [ALLW-1:0] bit_put(logic [ALLW-1:0] all,
                                               logic [SIDX_W-1:0] i, logic b);
    return (all & ~(ALLW'(1) << i)) | (ALLW'(b) << i);
  endfunction

  prog_mode_e        mode;
  logic [OFS_W-1:0]  dflt;
  logic              ser_we;
  logic [SIDX_W-1:0] ser_idx;
  logic              par_we;
  logic              par_re;
  logic [PIDX_W-1:0] par_idx;
  logic [BUS_W-1:0]  cur_word;
  logic [ALLW-1:0]   ofs_q;
  logic [BUS_W-1:0]  rd_q;

  ofs_mode_ctl #(.OFS_W(OFS_W), .DFLT_LO(DFLT_LO), .DFLT_HI(DFLT_HI)) u_mode (
    .clk_i (clk_i), .mrst_i (mrst_i), .prst_i (prst_i), .ld_i (ld_i),
    .mode_o (mode), .dflt_o (dflt)
  );

  ofs_ser_ctl #(.NBITS(ALLW), .SIDX_W(SIDX_W)) u_ser (
    .clk_i (clk_i), .mrst_i (mrst_i), .prst_i (prst_i), .mode_i (mode),
    .ser_en_i (ser_en_i), .ser_we_o (ser_we), .ser_idx_o (ser_idx)
  );

  ofs_par_ctl #(.NWORDS(NWORDS), .PIDX_W(PIDX_W)) u_par (
    .clk_i (clk_i), .mrst_i (mrst_i), .prst_i (prst_i), .mode_i (mode),
    .ld_i (ld_i), .wr_en_i (wr_en_i), .rd_en_i (rd_en_i),
    .par_we_o (par_we), .par_re_o (par_re), .par_idx_o (par_idx)
  );

  assign cur_word = word_get(ofs_q, int'(par_idx));

  always_ff @(posedge clk_i) begin
    if (mrst_i)      ofs_q <= {dflt, dflt};
    else if (ser_we) ofs_q <= bit_put(ofs_q, ser_idx, ser_bit_i);
    else if (par_we) ofs_q <= word_put(ofs_q, int'(par_idx), wr_data_i);
  end

  // readback samples the slot before this clock's write lands
  always_ff @(posedge clk_i) begin
    if (mrst_i || prst_i) rd_q <= '0;
    else if (par_re)      rd_q <= cur_word;
  end

  assign empty_ofs_o = ofs_q[OFS_W-1:0];
  assign full_ofs_o  = ofs_q[ALLW-1:OFS_W];
  assign rd_data_o   = rd_q;

  a_r5_bit_lands: assert property (@(posedge clk_i) disable iff (mrst_i)
    ser_we |=> (((ofs_q >> $past(ser_idx)) & ALLW'(1)) == ALLW'($past(ser_bit_i))));
  a_r6_no_par_in_ser: assert property (@(posedge clk_i) disable iff (mrst_i)
    (mode == PROG_SER) |-> (!par_we && !par_re));
  a_r10_no_ser_in_par: assert property (@(posedge clk_i) disable iff (mrst_i)
    (mode == PROG_PAR) |-> !ser_we);
  a_r9_store_idle: assert property (@(posedge clk_i) disable iff (mrst_i)
    (!ser_we && !par_we) |=> $stable(ofs_q));
  a_r11_old_word_out: assert property (@(posedge clk_i) disable iff (mrst_i)
    (par_we && par_re) |=> (rd_q == $past(cur_word)));
  a_r12_quiet_in_mrst: assert property (@(posedge clk_i) disable iff (prst_i)
    mrst_i |-> (!ser_we && !par_we && !par_re));
endmodule

// File: tb/flag_offset_unit_tb.sv
module flag_offset_unit_tb;
  logic        clk = 1'b0;
  logic        mrst, prst, ld, sen, sbit, wen, ren;
  logic [8:0]  din;
  logic [15:0] e_ofs, f_ofs;
  logic [8:0]  rdat;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #4 clk = ~clk;

  flag_offset_unit u_dut (
    .clk_i (clk), .mrst_i (mrst), .prst_i (prst), .ld_i (ld),
    .ser_en_i (sen), .ser_bit_i (sbit), .wr_en_i (wen), .rd_en_i (ren),
    .wr_data_i (din), .empty_ofs_o (e_ofs), .full_ofs_o (f_ofs),
    .rd_data_o (rdat)
  );

  typedef struct packed {
    logic        prst;
    logic        ld;
    logic        wen;
    logic        ren;
    logic        sen;
    logic        sbit;
    logic [8:0]  din;
    logic [15:0] e;
    logic [15:0] f;
    logic [8:0]  rd;
    logic [7:0]  req;
  } vec_t;

  // parallel mode, starting from defaults 127/127, pointer at slot 0
  localparam vec_t TBL [0:14] = '{
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,9'h1A5,16'h01A5,16'h007F,9'h000,8'd7},  // R7 slot0
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,9'h1FF,16'hFFA5,16'h007F,9'h000,8'd7},  // R7 bits 8:7 dropped
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,9'h033,16'hFFA5,16'h0033,9'h000,8'd7},  // R7 slot2
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,9'h105,16'hFFA5,16'h0A33,9'h000,8'd7},  // R7 slot3
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,9'h000,16'hFFA5,16'h0A33,9'h000,8'd9},  // R9 write without load
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,9'h000,16'hFFA5,16'h0A33,9'h000,8'd9},  // R9 read without load
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,9'h000,16'hFFA5,16'h0A33,9'h1A5,8'd8},  // R8 pointer wrapped
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,9'h000,16'hFFA5,16'h0A33,9'h07F,8'd8},  // R8 zero pad
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,9'h000,16'hFFA5,16'h0A33,9'h033,8'd8},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,9'h000,16'hFFA5,16'h0A33,9'h005,8'd8},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,9'h0C3,16'hFEC3,16'h0A33,9'h1A5,8'd11}, // R11 collide
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,9'h000,16'hFEC3,16'h0A33,9'h07F,8'd11}, // R11 one step
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,9'h000,16'hFEC3,16'h0A33,9'h07F,8'd10}, // R10 serial ignored
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,9'h000,16'hFEC3,16'h0A33,9'h000,8'd4},  // R4 partial reset
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,9'h000,16'hFEC3,16'h0A33,9'h0C3,8'd4}   // R4 pointer restart
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic drive(input logic mr, input logic pr, input logic l, input logic se,
                       input logic sb, input logic we, input logic re, input logic [8:0] d);
    mrst = mr; prst = pr; ld = l; sen = se; sbit = sb; wen = we; ren = re; din = d;
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pat;
    mrst = 1'b1; prst = 1'b0; ld = 1'b0; sen = 1'b0; sbit = 1'b0;
    wen = 1'b0; ren = 1'b0; din = '0;
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000);
    chk("R1 empty default", e_ofs, 16'h007F);
    chk("R1 full default", f_ofs, 16'h007F);
    chk("R3 readback cleared", {7'b0, rdat}, 16'h0000);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000);

    for (int i = 0; i < 15; i++) begin
      drive(1'b0, TBL[i].prst, TBL[i].ld, TBL[i].sen, TBL[i].sbit,
            TBL[i].wen, TBL[i].ren, TBL[i].din);
      chk($sformatf("R%0d row%0d empty", TBL[i].req, i), e_ofs, TBL[i].e);
      chk($sformatf("R%0d row%0d full", TBL[i].req, i), f_ofs, TBL[i].f);
      chk($sformatf("R%0d row%0d rd", TBL[i].req, i), {7'b0, rdat}, {7'b0, TBL[i].rd});
    end

    // R3: master reset mid-sequence clears readback and pointer
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 9'h000);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000);
    chk("R3 rd cleared by master reset", {7'b0, rdat}, 16'h0000);
    chk("R1 defaults restored", e_ofs, 16'h007F);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 9'h000);
    chk("R3 pointer back at slot0", {7'b0, rdat}, 16'h007F);

    // R2 and R12: serial default while other inputs are active
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 9'h000);
    chk("R2 empty default", e_ofs, 16'h03FF);
    chk("R12 full untouched in reset", f_ofs, 16'h03FF);
    chk("R12 rd untouched in reset", {7'b0, rdat}, 16'h0000);

    // R5: serial load, empty offset first, LSB first
    pat = {16'h91B3, 16'h2C5A};
    for (int k = 0; k < 32; k++) begin
      drive(1'b0, 1'b0, 1'b0, 1'b1, pat[k], 1'b0, 1'b0, 9'h000);
      if (k == 15) begin
        chk("R5 empty after 16 bits", e_ofs, 16'h2C5A);
        chk("R5 full not yet reached", f_ofs, 16'h03FF);
      end
    end
    chk("R5 full after 32 bits", f_ofs, 16'h91B3);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
    chk("R5 no shift without enable", e_ofs, 16'h2C5A);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h000);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h000);
    chk("R5 wrap into empty low bits", e_ofs, 16'h2C5D);
    chk("R5 full kept on wrap", f_ofs, 16'h91B3);

    // R6: parallel access in serial mode
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'h155);
    chk("R6 empty kept", e_ofs, 16'h2C5D);
    chk("R6 full kept", f_ofs, 16'h91B3);
    chk("R6 rd kept", {7'b0, rdat}, 16'h0000);

    // R4: partial reset in serial mode
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h000);
    chk("R4 empty kept", e_ofs, 16'h2C5D);
    chk("R4 full kept", f_ofs, 16'h91B3);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000);
    chk("R4 serial restarts at bit0", e_ofs, 16'h2C5C);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule